// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block contains two up-counting timer/counter units for a small controller. Each unit has a low and a high count byte. It advances either once per machine-cycle strobe (timer function) or once per falling edge seen on its count pin (counter function). A mode byte selects one of four counting modes for each unit:

- a 13-bit prescaled count;
- a full 16-bit count;
- an 8-bit count that reloads itself from the high byte;
- a split mode, in which unit 0 becomes two independent 8-bit counters and unit 1 stops.

A control byte holds the run bits, the overflow flags, and the flags of two external interrupt lines with their edge/level selects. The core writes the six registers as whole bytes. The control byte can also be written one bit at a time. An interrupt controller acknowledges flags through separate pulse inputs.

All pins are sampled on the machine-cycle strobe `tickEn`, which the surrounding core drives once per machine cycle. A falling edge is therefore recognised on the second strobe after the pin drops. This limits the counter function to one count per two machine cycles.

Top module: `twin_tick_counter`

## Requirements

- R1: After reset, all six registers read 0x00 and every flag output is 0.

- R2: Register addresses are as follows:
  - 0: low byte of unit 0; 1: high byte of unit 0.
  - 2: low byte of unit 1; 3: high byte of unit 1.
  - 4: mode byte. Unit 1 uses bits [7:4] and unit 0 uses bits [3:0]. Within each nibble, bit 3 is gate, bit 2 is count-pin select, and bits 1:0 are the mode.
  - 5: control byte. Bit 7 is overflow 1, bit 6 is run 1, bit 5 is overflow 0, bit 4 is run 0, bit 3 is ext flag 1, bit 2 is ext edge select 1, bit 1 is ext flag 0, and bit 0 is ext edge select 0.
  - Every address reads back on `rdData`. A single-bit write changes only the selected control bit. The mode byte changes only on a byte write to address 4.

- R3: In the timer function (select 0), a unit whose run bit is 1 advances by one on every cycle with `tickEn` high. With `tickEn` low and no write, no count changes.

- R4: Mode 1 counts over the 16 bits {high, low}. A rollover from 0xFFFF to 0x0000 sets the unit's overflow flag.

- R5: Mode 0 counts over the 13 bits {high, low[4:0]}. Low[7:5] is held. A rollover from all ones sets the overflow flag.

- R6: Mode 2 counts only the low byte. When the low byte passes 0xFF, it is loaded with the high byte and the overflow flag is set.

- R7: When unit 0 is in mode 3, its low byte counts with run 0 and overflow 0. Its high byte counts machine cycles with run 1 and sets overflow 1. Unit 1 in mode 3 holds its count whatever its run bit.

- R8: In the counter function (select 1), a unit advances once per 1-to-0 transition of its count pin. The pin is sampled on `tickEn`, and the count is taken on the second strobe after the fall.

- R9: With gate set, a unit advances only while its external interrupt pin, as sampled on `tickEn`, is high.

- R10: A byte write to a unit's count register in the same cycle as an increment takes priority. The written value is stored and the increment for that byte group is dropped.

- R11: An `ackOvf` pulse clears the matching overflow flag. A hardware set in the same cycle wins over the acknowledge. Any software write to the control byte wins over both.

- R12: An external flag is handled according to its edge select:
  - With edge select 1, the flag is set by a sampled falling edge of its `extIntN` pin.
  - With edge select 0, the flag is set on every strobe that samples the pin low.
  - In either case, an `ackExt` pulse clears the flag.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Machine-cycle strobe |
| wrEn | input | 1 | Byte write enable |
| wrAddr | input | 3 | Byte write address |
| wrData | input | 8 | Byte write data |
| bitWrEn | input | 1 | Control-byte single-bit write enable |
| bitSel | input | 3 | Bit index for the single-bit write |
| bitVal | input | 1 | Value for the single-bit write |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data (combinational) |
| cntPin | input | 2 | Count pins, one per unit |
| extIntN | input | 2 | External interrupt pins, active low |
| ackOvf | input | 2 | Overflow flag acknowledge pulses |
| ackExt | input | 2 | External flag acknowledge pulses |
| ovfFlag | output | 2 | Overflow flags (unit 1 in bit 1) |
| extFlag | output | 2 | External interrupt flags |

## Verification

The bound checker watches, on every cycle, the following behaviours:

- the mode byte holds unless it is written;
- counts freeze when there is no strobe and no write;
- unit 1 holds in mode 3;
- an acknowledge clears an overflow flag when nothing sets it;
- flags rise only after a strobe or a software write.

The arithmetic of each mode needs the bench's scenarios. These cover the 13-bit carry, the reload value, the split-mode flag routing, the two-strobe edge count, gating, and write priority. The bench checks them against counts computed by its own model.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    MODE_PRE13   = 2'd0,
    MODE_FULL16  = 2'd1,
    MODE_RELOAD8 = 2'd2,
    MODE_SPLIT   = 2'd3
  } mode_e;

  localparam logic [2:0] ADDR_LO0  = 3'd0;
  localparam logic [2:0] ADDR_HI0  = 3'd1;
  localparam logic [2:0] ADDR_LO1  = 3'd2;
  localparam logic [2:0] ADDR_HI1  = 3'd3;
  localparam logic [2:0] ADDR_MODE = 3'd4;
  localparam logic [2:0] ADDR_CTRL = 3'd5;

  // control byte bit positions
  localparam int B_OVF1 = 7;
  localparam int B_RUN1 = 6;
  localparam int B_OVF0 = 5;
  localparam int B_RUN0 = 4;
  localparam int B_XF1  = 3;
  localparam int B_XE1  = 2;
  localparam int B_XF0  = 1;
  localparam int B_XE0  = 0;

  // strobes from control to datapath, one per unit
  typedef struct packed {
    logic  incLo;
    logic  incHi;
    mode_e mode;
  } unitStb_t;
endpackage

// File: rtl/tick_datapath.sv
module tick_datapath
  import tick_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  unitStb_t          stb [2],
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] cntLo [2],
  output logic [BYTE_W-1:0] cntHi [2],
  output logic              wrapLo [2],
  output logic              wrapHi [2]
);
  localparam int WIDE_W = 2 * BYTE_W;
  localparam int PRE_T  = BYTE_W + PRE_W;

  for (genvar u = 0; u < 2; u++) begin : g_unit
    localparam logic [2:0] LO_A = 3'(2 * u);
    localparam logic [2:0] HI_A = 3'(2 * u + 1);
    logic [BYTE_W-1:0] loQ, hiQ, nxtLo, nxtHi;
    logic wLo, wHi;

    always_comb begin
      nxtLo = loQ;
      nxtHi = hiQ;
      wLo   = 1'b0;
      wHi   = 1'b0;
      unique case (stb[u].mode)
        MODE_PRE13: if (stb[u].incLo) begin
          {nxtHi, nxtLo[PRE_W-1:0]} = {hiQ, loQ[PRE_W-1:0]} + PRE_T'(1);
          wLo = &{hiQ, loQ[PRE_W-1:0]};
        end
        MODE_FULL16: if (stb[u].incLo) begin
          {nxtHi, nxtLo} = {hiQ, loQ} + WIDE_W'(1);
          wLo = &{hiQ, loQ};
        end
        MODE_RELOAD8: if (stb[u].incLo) begin
          wLo   = &loQ;
          nxtLo = wLo ? hiQ : loQ + BYTE_W'(1);
        end
        MODE_SPLIT: begin
          if (stb[u].incLo) begin
            nxtLo = loQ + BYTE_W'(1);
            wLo   = &loQ;
          end
          if (stb[u].incHi) begin
            nxtHi = hiQ + BYTE_W'(1);
            wHi   = &hiQ;
          end
        end
        default: ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        loQ <= '0;
        hiQ <= '0;
      end else begin
        loQ <= (wrEn && wrAddr == LO_A) ? wrData : nxtLo;
        hiQ <= (wrEn && wrAddr == HI_A) ? wrData : nxtHi;
      end
    end

    assign cntLo[u]  = loQ;
    assign cntHi[u]  = hiQ;
    assign wrapLo[u] = wLo;
    assign wrapHi[u] = wHi;
  end
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
  import tick_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              bitWrEn,
  input  logic [2:0]        bitSel,
  input  logic              bitVal,
  input  logic [1:0]        cntPin,
  input  logic [1:0]        extIntN,
  input  logic [1:0]        ackOvf,
  input  logic [1:0]        ackExt,
  input  logic              wrapLo [2],
  input  logic              wrapHi [2],
  output unitStb_t          stb [2],
  output logic [BYTE_W-1:0] modeReg,
  output logic [BYTE_W-1:0] ctrlReg
);
  logic [1:0] cntSamp, cntPrev, extSamp, extPrev;
  logic [1:0] cntFall, extFall, evt, allow, gate, cSel, edgeSel, extSet;
  logic [1:0] wLo, wHi, run;
  mode_e      mode [2];
  logic       split, ovf0Set, ovf1Set;
  logic [BYTE_W-1:0] ctrlNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntSamp <= '1;
      cntPrev <= '1;
      extSamp <= '1;
      extPrev <= '1;
    end else if (tickEn) begin
      cntSamp <= cntPin;
      cntPrev <= cntSamp;
      extSamp <= extIntN;
      extPrev <= extSamp;
    end
  end

  assign cntFall = {2{tickEn}} & cntPrev & ~cntSamp;
  assign extFall = {2{tickEn}} & extPrev & ~extSamp;
  assign run     = {ctrlReg[B_RUN1], ctrlReg[B_RUN0]};
  assign edgeSel = {ctrlReg[B_XE1], ctrlReg[B_XE0]};

  for (genvar u = 0; u < 2; u++) begin : g_evt
    assign gate[u]   = modeReg[4*u+3];
    assign cSel[u]   = modeReg[4*u+2];
    assign mode[u]   = mode_e'(modeReg[4*u+1 -: 2]);
    assign evt[u]    = cSel[u] ? cntFall[u] : tickEn;
    assign allow[u]  = run[u] & (~gate[u] | extSamp[u]);
    assign wLo[u]    = wrEn && wrAddr == 3'(2 * u);
    assign wHi[u]    = wrEn && wrAddr == 3'(2 * u + 1);
    assign extSet[u] = edgeSel[u] ? extFall[u] : (tickEn & ~extSamp[u]);
  end

  assign split = (mode[0] == MODE_SPLIT);

  always_comb begin
    stb[0].mode  = mode[0];
    stb[0].incLo = allow[0] & evt[0] & ~wLo[0] & (split | ~wHi[0]);
    stb[0].incHi = split & run[1] & tickEn & ~wHi[0];
    stb[1].mode  = mode[1];
    stb[1].incLo = (mode[1] != MODE_SPLIT) & allow[1] & evt[1] & ~wLo[1] & ~wHi[1];
    stb[1].incHi = 1'b0;
  end

  assign ovf0Set = wrapLo[0];
  assign ovf1Set = split ? wrapHi[0] : wrapLo[1];

  always_comb begin
    ctrlNxt = ctrlReg;
    if (ovf0Set) ctrlNxt[B_OVF0] = 1'b1;
    else if (ackOvf[0]) ctrlNxt[B_OVF0] = 1'b0;
    if (ovf1Set) ctrlNxt[B_OVF1] = 1'b1;
    else if (ackOvf[1]) ctrlNxt[B_OVF1] = 1'b0;
    if (extSet[0]) ctrlNxt[B_XF0] = 1'b1;
    else if (ackExt[0]) ctrlNxt[B_XF0] = 1'b0;
    if (extSet[1]) ctrlNxt[B_XF1] = 1'b1;
    else if (ackExt[1]) ctrlNxt[B_XF1] = 1'b0;
    if (wrEn && wrAddr == ADDR_CTRL) ctrlNxt = wrData;
    if (bitWrEn) ctrlNxt[bitSel] = bitVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      modeReg <= '0;
    end else begin
      ctrlReg <= ctrlNxt;
      if (wrEn && wrAddr == ADDR_MODE) modeReg <= wrData;
    end
  end
endmodule

// File: rtl/twin_tick_counter.sv
module twin_tick_counter
  import tick_pkg::*;
#(
  parameter int PRE_W = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tickEn,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic       bitWrEn,
  input  logic [2:0] bitSel,
  input  logic       bitVal,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  input  logic [1:0] cntPin,
  input  logic [1:0] extIntN,
  input  logic [1:0] ackOvf,
  input  logic [1:0] ackExt,
  output logic [1:0] ovfFlag,
  output logic [1:0] extFlag
);
  unitStb_t          stb [2];
  logic [BYTE_W-1:0] cntLo [2];
  logic [BYTE_W-1:0] cntHi [2];
  logic              wrapLo [2];
  logic              wrapHi [2];
  logic [BYTE_W-1:0] modeReg, ctrlReg;

  tick_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .bitWrEn(bitWrEn), .bitSel(bitSel), .bitVal(bitVal),
    .cntPin(cntPin), .extIntN(extIntN), .ackOvf(ackOvf), .ackExt(ackExt),
    .wrapLo(wrapLo), .wrapHi(wrapHi), .stb(stb),
    .modeReg(modeReg), .ctrlReg(ctrlReg)
  );

  tick_datapath #(.PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntLo(cntLo), .cntHi(cntHi), .wrapLo(wrapLo), .wrapHi(wrapHi)
  );

  always_comb begin
    unique case (rdAddr)
      ADDR_LO0:  rdData = cntLo[0];
      ADDR_HI0:  rdData = cntHi[0];
      ADDR_LO1:  rdData = cntLo[1];
      ADDR_HI1:  rdData = cntHi[1];
      ADDR_MODE: rdData = modeReg;
      ADDR_CTRL: rdData = ctrlReg;
      default:   rdData = '0;
    endcase
  end

  assign ovfFlag = {ctrlReg[B_OVF1], ctrlReg[B_OVF0]};
  assign extFlag = {ctrlReg[B_XF1], ctrlReg[B_XF0]};
endmodule

// File: rtl/tick_checker.sv
module tick_checker (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic       bitWrEn,
  input logic [1:0] ackOvf,
  input logic [7:0] modeReg,
  input logic [7:0] lo0,
  input logic [7:0] hi0,
  input logic [7:0] lo1,
  input logic [7:0] hi1,
  input logic [1:0] ovfFlag,
  input logic [1:0] extFlag
);
  // R2
  mode_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && wrAddr == 3'd4) |=> $stable(modeReg));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !wrEn) |=> $stable({hi1, lo1, hi0, lo0}));

  // R7
  split_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[5:4] == 2'b11 && !(wrEn && (wrAddr == 3'd2 || wrAddr == 3'd3)))
      |=> $stable({hi1, lo1}));

  // R11
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ackOvf[0] && !tickEn && !wrEn && !bitWrEn) |=> !ovfFlag[0]);

  // R4
  ovf_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovfFlag[0]) |-> ($past(tickEn) || $past(wrEn || bitWrEn)));

  // R12
  ext_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extFlag[1]) |-> ($past(tickEn) || $past(wrEn || bitWrEn)));
endmodule

bind twin_tick_counter tick_checker u_chk (
  .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
  .bitWrEn(bitWrEn), .ackOvf(ackOvf), .modeReg(modeReg),
  .lo0(cntLo[0]), .hi0(cntHi[0]), .lo1(cntLo[1]), .hi1(cntHi[1]),
  .ovfFlag(ovfFlag), .extFlag(extFlag)
);

// File: tb/test_twin_tick_counter.sv
module test_twin_tick_counter;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       bitWrEn = 1'b0;
  logic [2:0] bitSel = '0;
  logic       bitVal = 1'b0;
  logic [2:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [1:0] cntPin = 2'b11;
  logic [1:0] extIntN = 2'b11;
  logic [1:0] ackOvf = '0;
  logic [1:0] ackExt = '0;
  logic [1:0] ovfFlag, extFlag;

  int  nTests = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  twin_tick_counter i_twin_tick_counter (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .bitWrEn(bitWrEn), .bitSel(bitSel), .bitVal(bitVal),
    .rdAddr(rdAddr), .rdData(rdData), .cntPin(cntPin), .extIntN(extIntN),
    .ackOvf(ackOvf), .ackExt(ackExt), .ovfFlag(ovfFlag), .extFlag(extFlag)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic bitWr(logic [2:0] s, logic v);
    @(negedge clk);
    bitWrEn = 1'b1; bitSel = s; bitVal = v;
    @(negedge clk);
    bitWrEn = 1'b0;
  endtask

  task automatic ticks(int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  // expected {flag, hi, lo} after n increments
  function automatic logic [16:0] model(int m, logic [7:0] lo, logic [7:0] hi, int n);
    logic f = 1'b0;
    for (int i = 0; i < n; i++) begin
      case (m)
        0: begin
          logic [12:0] v = {hi, lo[4:0]};
          if (v == 13'h1FFF) f = 1'b1;
          v = v + 13'd1;
          hi = v[12:5];
          lo[4:0] = v[4:0];
        end
        1: begin
          logic [15:0] v = {hi, lo};
          if (v == 16'hFFFF) f = 1'b1;
          v = v + 16'd1;
          {hi, lo} = v;
        end
        default: begin
          if (lo == 8'hFF) begin f = 1'b1; lo = hi; end
          else lo = lo + 8'd1;
        end
      endcase
    end
    return {f, hi, lo};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nTests++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", nTests, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2;
    logic [16:0] e;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      check("R1 reg", d, 0);
    end
    check("R1 flags", {ovfFlag, extFlag}, 0);

    // R4 / R3: mode 1 rollover
    wr(4, 8'h01); wr(0, 8'hF0); wr(1, 8'hFF); wr(5, 8'h10);
    ticks(20);
    rd(0, d); rd(1, d2);
    check("R4 count", {d2, d}, 16'h0004);
    check("R4 flag", ovfFlag[0], 1);
    // R11 acknowledge clears
    @(negedge clk); ackOvf[0] = 1'b1;
    @(negedge clk); ackOvf[0] = 1'b0;
    check("R11 ack", ovfFlag[0], 0);

    // R5: mode 0 13-bit, low[7:5] held
    wr(5, 8'h00); wr(4, 8'h00); wr(0, 8'hFE); wr(1, 8'hFF); wr(5, 8'h10);
    ticks(3);
    e = model(0, 8'hFE, 8'hFF, 3);
    rd(0, d); rd(1, d2);
    check("R5 count", {d2, d}, e[15:0]);
    check("R5 flag", ovfFlag[0], e[16]);

    // R6: mode 2 reload
    wr(5, 8'h00); wr(4, 8'h02); wr(0, 8'hFE); wr(1, 8'h50); wr(5, 8'h10);
    ticks(4);
    rd(0, d); rd(1, d2);
    check("R6 count", {d2, d}, 16'h5052);
    check("R6 flag", ovfFlag[0], 1);

    // R7: split mode, unit 1 holds
    wr(5, 8'h00); wr(4, 8'h33);
    wr(0, 8'hFE); wr(1, 8'hFD); wr(2, 8'hAA); wr(3, 8'hBB);
    wr(5, 8'h50);
    ticks(3);
    rd(0, d); rd(1, d2);
    check("R7 split", {d2, d}, 16'h0001);
    check("R7 flags", ovfFlag, 2'b11);
    rd(2, d); rd(3, d2);
    check("R7 hold", {d2, d}, 16'hBBAA);

    // R10: write beats increment
    wr(5, 8'h00); wr(4, 8'h01); wr(0, 8'h00); wr(1, 8'h00); wr(5, 8'h10);
    @(negedge clk); tickEn = 1'b1;
    repeat (3) @(negedge clk);
    wrEn = 1'b1; wrAddr = 3'd0; wrData = 8'h33;
    @(negedge clk); wrEn = 1'b0; tickEn = 1'b0;
    rd(0, d); rd(1, d2);
    check("R10 write", {d2, d}, 16'h0033);

    // R8: counter function, 3 falling edges
    wr(5, 8'h00); wr(4, 8'h05); wr(0, 8'h00); wr(1, 8'h00); wr(5, 8'h10);
    @(negedge clk); tickEn = 1'b1;
    for (int p = 0; p < 3; p++) begin
      cntPin[0] = 1'b0; repeat (2) @(negedge clk);
      cntPin[0] = 1'b1; repeat (2) @(negedge clk);
    end
    tickEn = 1'b0;
    rd(0, d);
    check("R8 edges", d, 3);

    // R9: gate
    wr(5, 8'h00); wr(4, 8'h09);
    extIntN[0] = 1'b0; ticks(2);
    wr(0, 8'h00); wr(1, 8'h00); wr(5, 8'h10);
    ticks(5);
    rd(0, d);
    check("R9 gated", d, 0);
    extIntN[0] = 1'b1; ticks(5);
    rd(0, d);
    check("R9 open", d, 4);

    // R2: single-bit control write
    wr(5, 8'h00); bitWr(4, 1'b1); bitWr(2, 1'b1);
    rd(5, d);
    check("R2 bitwr", d, 8'h14);
    wr(4, 8'h00);
    rd(4, d);
    check("R2 mode", d, 0);

    // R12: edge then level external flags
    wr(5, 8'h01);
    extIntN[0] = 1'b0; ticks(3);
    check("R12 edge set", extFlag[0], 1);
    extIntN[0] = 1'b1; ticks(2);
    @(negedge clk); ackExt[0] = 1'b1;
    @(negedge clk); ackExt[0] = 1'b0;
    check("R12 edge ack", extFlag[0], 0);
    wr(5, 8'h00);
    extIntN[1] = 1'b0; ticks(2);
    check("R12 level set", extFlag[1], 1);
    @(negedge clk); ackExt[1] = 1'b1;
    @(negedge clk); ackExt[1] = 1'b0;
    check("R12 level ack", extFlag[1], 0);
    extIntN[1] = 1'b1; ticks(2);

    // R3 / R4 / R5 / R6: random runs on unit 1
    for (int k = 0; k < 24; k++) begin
      int m = int'($urandom_range(0, 2));
      logic [7:0] lo = 8'($urandom);
      logic [7:0] hi = 8'($urandom);
      int n = int'($urandom_range(1, 300));
      wr(5, 8'h00); wr(4, 8'(m << 4)); wr(2, lo); wr(3, hi); wr(5, 8'h40);
      ticks(n);
      e = model(m, lo, hi, n);
      rd(2, d); rd(3, d2);
      check("R3 random count", {d2, d}, e[15:0]);
      check("R4 random flag", ovfFlag[1], e[16]);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule